// File: doc/BRIEF.md
# Translation Cache with Shootdown

This block holds recent translations for an I/O address translation unit that maps 32-bit virtual addresses onto 4 KB physical pages. It has two fully associative stores. The page store holds up to eight translations, each tagged by virtual page number. The directory store holds up to four second-level table base addresses, each tagged by the top ten address bits. A lookup presents a full virtual address. One cycle later the block answers with a page hit, the physical page number and the eight attribute flags, and separately with a directory hit and the table base. On a miss, the table walker writes the result back through the fill ports.

Stale state is removed in two ways. A line shootdown takes a full address, ignores its offset, and drops the matching page entry. It also drops any directory entry for the 4 MB region that the address falls in, so software evicts a stale directory copy by shooting down the first page of that region. The whole cache empties in one cycle on three inputs: an explicit flush, the end of fault handling, and a force clear. Each store decides what to do with a fill every cycle: ignore it, drop it, update an entry in place, or allocate a new entry.

Top module: `xlat_cache`

## Requirements
- R1: After reset, and in the cycle after `force_clr`, every lookup misses in both stores, and `rsp_valid` stays low while reset is held.
- R2: A lookup is answered exactly one cycle after `lookup_valid`, with `rsp_valid` high for that single cycle. The lookup sees the contents from before any fill or invalidate applied on the same clock edge.
- R3: After a page fill, a lookup whose address bits 31:12 equal the filled page number hits, whatever its offset bits 11:0 are. It returns the filled 20-bit physical page number and the 8-bit flags. A missing page returns zero page number and zero flags.
- R4: A line shootdown clears the page entry whose page number equals its address bits 31:12. Its bits 11:0 are ignored, and other pages are not affected.
- R5: A line shootdown also clears any directory entry whose tag equals its address bits 31:22.
- R6: `zap_all` invalidates every entry of both stores in a single cycle.
- R7: `fault_done` flushes both stores in the same way as `zap_all`.
- R8: A fill that arrives in the same cycle as a flush, or as a line shootdown of the same page (or the same directory index), leaves that entry invalid.
- R9: The page store replaces entries round robin over 8 slots. A fill of a page that is not present writes the slot under a pointer and then advances the pointer, wrapping after slot 7. The pointer returns to slot 0 on reset and on any flush, so the ninth distinct fill after a flush evicts the first.
- R10: A fill of a page that is already present rewrites that entry in place and does not advance the replacement pointer.
- R11: The directory store holds 4 entries tagged by address bits 31:22, each holding a 20-bit table base, with the same round-robin and in-place rules. A lookup reports a directory hit and the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| force_clr | input | 1 | Force clear: empty both stores |
| fault_done | input | 1 | Fault handled: flush both stores |
| zap_all | input | 1 | Explicit flush of both stores |
| zap_line_valid | input | 1 | Line shootdown request |
| zap_line_va | input | 32 | Shootdown address; bits 11:0 ignored |
| fill_valid | input | 1 | Page fill from the walker |
| fill_vpn | input | 20 | Virtual page number being filled |
| fill_ppn | input | 20 | Physical page number |
| fill_flags | input | 8 | Attribute flags (table-entry bits 8:1) |
| dfill_valid | input | 1 | Directory fill from the walker |
| dfill_dix | input | 10 | Directory index (address bits 31:22) |
| dfill_base | input | 20 | Second-level table base, bits 31:12 |
| lookup_valid | input | 1 | Lookup request |
| lookup_va | input | 32 | Lookup address |
| rsp_valid | output | 1 | Lookup answer valid |
| rsp_hit | output | 1 | Page hit |
| rsp_ppn | output | 20 | Physical page number, zero on miss |
| rsp_flags | output | 8 | Flags, zero on miss |
| rsp_dir_hit | output | 1 | Directory hit |
| rsp_pt_base | output | 20 | Table base, zero on miss |

## Verification
The bench goes after the collisions. A lookup in the same cycle as a fill or shootdown must see the old contents; a design that forwarded the new state would report a hit one cycle early or a stale miss. Fills that collide with a shootdown or a flush must stay dropped; a design that let the fill win would keep serving a translation software has just removed. The bench also shoots down a page inside a cached directory region, which a design without the directory side effect would leave live. Finally it counts evictions across wrap, in-place refill and flush, where a pointer that advanced on refill or survived a flush evicts the wrong victim.

// File: rtl/xlat_cache_pkg.sv
package xlat_cache_pkg;

    // Per-cycle decision a store makes about an incoming fill
    typedef enum logic [1:0] {
        WR_IDLE   = 2'd0,   // no fill, or a flush overrides it
        WR_DROP   = 2'd1,   // same-tag invalidate wins
        WR_UPDATE = 2'd2,   // tag already present: rewrite in place
        WR_ALLOC  = 2'd3    // new tag: take the round-robin slot
    } wr_act_e;

endpackage

// File: rtl/xlat_assoc_store.sv
module xlat_assoc_store
    import xlat_cache_pkg::*;
#(
    parameter int N      = 8,
    parameter int TAG_W  = 20,
    parameter int DATA_W = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              inv_en,
    input  logic [TAG_W-1:0]  inv_tag,
    input  logic              fill_en,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    input  logic [TAG_W-1:0]  look_tag,
    output logic              look_hit,
    output logic [DATA_W-1:0] look_data
);

    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(N - 1);

    logic [N-1:0]      vld_q, vld_d;
    logic [TAG_W-1:0]  tag_q [N];
    logic [DATA_W-1:0] dat_q [N];
    logic [IDX_W-1:0]  ptr_q, ptr_d;
    logic [IDX_W-1:0]  upd_idx, wr_idx;
    logic [N-1:0]      fill_hit_v, inv_hit_v, look_hit_v;
    wr_act_e           act;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_cmp
            assign fill_hit_v[g] = vld_q[g] && (tag_q[g] == fill_tag);
            assign inv_hit_v[g]  = inv_en && vld_q[g] && (tag_q[g] == inv_tag);
            assign look_hit_v[g] = vld_q[g] && (tag_q[g] == look_tag);
        end
    endgenerate

    // Slot holding the fill tag, if any
    always_comb begin
        upd_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (fill_hit_v[i]) upd_idx = IDX_W'(i);
        end
    end

    // Lookup read: at most one slot matches
    always_comb begin
        look_data = '0;
        for (int i = 0; i < N; i++) begin
            if (look_hit_v[i]) look_data = look_data | dat_q[i];
        end
        look_hit = |look_hit_v;
    end

    // Fill decision: flush beats invalidate beats fill
    always_comb begin
        if (!fill_en || clr_all)                 act = WR_IDLE;
        else if (inv_en && inv_tag == fill_tag)  act = WR_DROP;
        else if (|fill_hit_v)                    act = WR_UPDATE;
        else                                     act = WR_ALLOC;
    end

    // Next-state logic
    always_comb begin
        vld_d  = vld_q & ~inv_hit_v;
        ptr_d  = ptr_q;
        wr_idx = upd_idx;
        unique case (act)
            WR_UPDATE: vld_d[upd_idx] = 1'b1;
            WR_ALLOC: begin
                wr_idx        = ptr_q;
                vld_d[ptr_q]  = 1'b1;
                ptr_d         = (ptr_q == LAST_SLOT) ? '0 : ptr_q + IDX_W'(1);
            end
            WR_IDLE, WR_DROP: ;
            default: ;
        endcase
        if (clr_all) begin
            vld_d = '0;
            ptr_d = '0;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            ptr_q <= '0;
        end else begin
            vld_q <= vld_d;
            ptr_q <= ptr_d;
        end
    end

    // Payload storage, qualified by the valid bits
    always_ff @(posedge clk) begin
        if (act == WR_UPDATE || act == WR_ALLOC) begin
            tag_q[wr_idx] <= fill_tag;
            dat_q[wr_idx] <= fill_data;
        end
    end

endmodule

// File: rtl/xlat_resp_reg.sv
module xlat_resp_reg #(
    parameter int PPN_W  = 20,
    parameter int FLG_W  = 8,
    parameter int BASE_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              look_en,
    input  logic              page_hit,
    input  logic [PPN_W-1:0]  page_ppn,
    input  logic [FLG_W-1:0]  page_flags,
    input  logic              dir_hit,
    input  logic [BASE_W-1:0] dir_base,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PPN_W-1:0]  rsp_ppn,
    output logic [FLG_W-1:0]  rsp_flags,
    output logic              rsp_dir_hit,
    output logic [BASE_W-1:0] rsp_pt_base
);

    logic take_page, take_dir;
    assign take_page = look_en && page_hit;
    assign take_dir  = look_en && dir_hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_hit     <= 1'b0;
            rsp_ppn     <= '0;
            rsp_flags   <= '0;
            rsp_dir_hit <= 1'b0;
            rsp_pt_base <= '0;
        end else begin
            rsp_valid   <= look_en;
            rsp_hit     <= take_page;
            rsp_ppn     <= take_page ? page_ppn   : '0;
            rsp_flags   <= take_page ? page_flags : '0;
            rsp_dir_hit <= take_dir;
            rsp_pt_base <= take_dir ? dir_base : '0;
        end
    end

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
    parameter int VA_W         = 32,
    parameter int PA_W         = 32,
    parameter int PAGE_LSB     = 12,
    parameter int DIR_LSB      = 22,
    parameter int FLG_W        = 8,
    parameter int PAGE_ENTRIES = 8,
    parameter int DIR_ENTRIES  = 4,
    localparam int VPN_W       = VA_W - PAGE_LSB,
    localparam int DIX_W       = VA_W - DIR_LSB,
    localparam int PPN_W       = PA_W - PAGE_LSB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             force_clr,
    input  logic             fault_done,
    input  logic             zap_all,
    input  logic             zap_line_valid,
    input  logic [VA_W-1:0]  zap_line_va,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic [FLG_W-1:0] fill_flags,
    input  logic             dfill_valid,
    input  logic [DIX_W-1:0] dfill_dix,
    input  logic [PPN_W-1:0] dfill_base,
    input  logic             lookup_valid,
    input  logic [VA_W-1:0]  lookup_va,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [PPN_W-1:0] rsp_ppn,
    output logic [FLG_W-1:0] rsp_flags,
    output logic             rsp_dir_hit,
    output logic [PPN_W-1:0] rsp_pt_base
);

    localparam int PDATA_W = PPN_W + FLG_W;

    logic               flush_any;
    logic               pg_hit, dir_hit;
    logic [PDATA_W-1:0] pg_data;
    logic [PPN_W-1:0]   dir_base;
    logic               offset_unused;

    assign flush_any     = force_clr | fault_done | zap_all;
    assign offset_unused = ^{zap_line_va[PAGE_LSB-1:0], lookup_va[PAGE_LSB-1:0]};

    xlat_assoc_store #(
        .N      (PAGE_ENTRIES),
        .TAG_W  (VPN_W),
        .DATA_W (PDATA_W)
    ) u_page_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_all   (flush_any),
        .inv_en    (zap_line_valid),
        .inv_tag   (zap_line_va[VA_W-1:PAGE_LSB]),
        .fill_en   (fill_valid),
        .fill_tag  (fill_vpn),
        .fill_data ({fill_ppn, fill_flags}),
        .look_tag  (lookup_va[VA_W-1:PAGE_LSB]),
        .look_hit  (pg_hit),
        .look_data (pg_data)
    );

    xlat_assoc_store #(
        .N      (DIR_ENTRIES),
        .TAG_W  (DIX_W),
        .DATA_W (PPN_W)
    ) u_dir_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_all   (flush_any),
        .inv_en    (zap_line_valid),
        .inv_tag   (zap_line_va[VA_W-1:DIR_LSB]),
        .fill_en   (dfill_valid),
        .fill_tag  (dfill_dix),
        .fill_data (dfill_base),
        .look_tag  (lookup_va[VA_W-1:DIR_LSB]),
        .look_hit  (dir_hit),
        .look_data (dir_base)
    );

    xlat_resp_reg #(
        .PPN_W  (PPN_W),
        .FLG_W  (FLG_W),
        .BASE_W (PPN_W)
    ) u_resp (
        .clk         (clk),
        .rst_n       (rst_n),
        .look_en     (lookup_valid),
        .page_hit    (pg_hit),
        .page_ppn    (pg_data[PDATA_W-1:FLG_W]),
        .page_flags  (pg_data[FLG_W-1:0]),
        .dir_hit     (dir_hit),
        .dir_base    (dir_base),
        .rsp_valid   (rsp_valid),
        .rsp_hit     (rsp_hit),
        .rsp_ppn     (rsp_ppn),
        .rsp_flags   (rsp_flags),
        .rsp_dir_hit (rsp_dir_hit),
        .rsp_pt_base (rsp_pt_base)
    );

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
    parameter int VPN_W = 20,
    parameter int DIX_W = 10,
    parameter int PPN_W = 20,
    parameter int FLG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             force_clr,
    input logic             fault_done,
    input logic             zap_all,
    input logic             zap_line_valid,
    input logic [VPN_W-1:0] zap_vpn,
    input logic [DIX_W-1:0] zap_dix,
    input logic             fill_valid,
    input logic [VPN_W-1:0] fill_vpn,
    input logic [PPN_W-1:0] fill_ppn,
    input logic [FLG_W-1:0] fill_flags,
    input logic             lookup_valid,
    input logic [VPN_W-1:0] look_vpn,
    input logic [DIX_W-1:0] look_dix,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [PPN_W-1:0] rsp_ppn,
    input logic [FLG_W-1:0] rsp_flags,
    input logic             rsp_dir_hit
);

    logic clr_any;
    assign clr_any = force_clr | fault_done | zap_all;

    p_resp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_valid |=> rsp_valid);

    p_no_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lookup_valid |=> !rsp_valid);

    // covers R6, R7 and the force-clear case of R1
    p_flush_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_valid && $past(clr_any)) |=> (!rsp_hit && !rsp_dir_hit));

    p_zap_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_valid && $past(zap_line_valid) && $past(zap_vpn) == look_vpn)
        |=> !rsp_hit);

    p_zap_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_valid && $past(zap_line_valid) && $past(zap_dix) == look_dix)
        |=> !rsp_dir_hit);

    p_inv_beats_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_valid && $past(fill_valid && zap_line_valid && zap_vpn == fill_vpn)
         && look_vpn == $past(fill_vpn)) |=> !rsp_hit);

    p_fill_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_valid && $past(fill_valid) && !$past(clr_any)
         && !($past(zap_line_valid) && $past(zap_vpn) == $past(fill_vpn))
         && look_vpn == $past(fill_vpn))
        |=> (rsp_hit && rsp_ppn == $past(fill_ppn, 2) && rsp_flags == $past(fill_flags, 2)));

    p_miss_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_ppn == '0 && rsp_flags == '0));

endmodule

bind xlat_cache xlat_cache_chk #(
    .VPN_W (VPN_W),
    .DIX_W (DIX_W),
    .PPN_W (PPN_W),
    .FLG_W (FLG_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .force_clr      (force_clr),
    .fault_done     (fault_done),
    .zap_all        (zap_all),
    .zap_line_valid (zap_line_valid),
    .zap_vpn        (zap_line_va[VA_W-1:PAGE_LSB]),
    .zap_dix        (zap_line_va[VA_W-1:DIR_LSB]),
    .fill_valid     (fill_valid),
    .fill_vpn       (fill_vpn),
    .fill_ppn       (fill_ppn),
    .fill_flags     (fill_flags),
    .lookup_valid   (lookup_valid),
    .look_vpn       (lookup_va[VA_W-1:PAGE_LSB]),
    .look_dix       (lookup_va[VA_W-1:DIR_LSB]),
    .rsp_valid      (rsp_valid),
    .rsp_hit        (rsp_hit),
    .rsp_ppn        (rsp_ppn),
    .rsp_flags      (rsp_flags),
    .rsp_dir_hit    (rsp_dir_hit)
);

// File: tb/test_xlat_cache.sv
module test_xlat_cache;

    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        force_clr, fault_done, zap_all, zap_line_valid;
    logic [31:0] zap_line_va;
    logic        fill_valid;
    logic [19:0] fill_vpn, fill_ppn;
    logic [7:0]  fill_flags;
    logic        dfill_valid;
    logic [9:0]  dfill_dix;
    logic [19:0] dfill_base;
    logic        lookup_valid;
    logic [31:0] lookup_va;
    logic        rsp_valid, rsp_hit, rsp_dir_hit;
    logic [19:0] rsp_ppn, rsp_pt_base;
    logic [7:0]  rsp_flags;

    always #(CLK_NS/2) clk = ~clk;

    xlat_cache i_xlat_cache (
        .clk(clk), .rst_n(rst_n), .force_clr(force_clr), .fault_done(fault_done),
        .zap_all(zap_all), .zap_line_valid(zap_line_valid), .zap_line_va(zap_line_va),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_flags(fill_flags), .dfill_valid(dfill_valid), .dfill_dix(dfill_dix),
        .dfill_base(dfill_base), .lookup_valid(lookup_valid), .lookup_va(lookup_va),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn),
        .rsp_flags(rsp_flags), .rsp_dir_hit(rsp_dir_hit), .rsp_pt_base(rsp_pt_base)
    );

    typedef struct {
        logic        hit;
        logic [19:0] ppn;
        logic [7:0]  flg;
        logic        dhit;
        logic [19:0] base;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   reported = 0;
    string cur_req = "";

    // Reference model built from the requirements
    bit          m_pv [8];
    logic [19:0] m_ptag [8];
    logic [19:0] m_pppn [8];
    logic [7:0]  m_pflg [8];
    int          m_pptr;
    bit          m_dv [4];
    logic [9:0]  m_dtag [4];
    logic [19:0] m_dbase [4];
    int          m_dptr;

    function automatic exp_t model_look(logic [31:0] va, string req);
        exp_t e;
        e.hit = 0; e.ppn = '0; e.flg = '0; e.dhit = 0; e.base = '0; e.req = req;
        for (int i = 0; i < 8; i++)
            if (m_pv[i] && m_ptag[i] == va[31:12]) begin
                e.hit = 1; e.ppn = m_pppn[i]; e.flg = m_pflg[i];
            end
        for (int i = 0; i < 4; i++)
            if (m_dv[i] && m_dtag[i] == va[31:22]) begin
                e.dhit = 1; e.base = m_dbase[i];
            end
        return e;
    endfunction

    function automatic void model_apply();
        bit found;
        if (zap_all || fault_done || force_clr) begin
            for (int i = 0; i < 8; i++) m_pv[i] = 0;
            for (int i = 0; i < 4; i++) m_dv[i] = 0;
            m_pptr = 0; m_dptr = 0;
            return;
        end
        if (zap_line_valid) begin
            for (int i = 0; i < 8; i++) if (m_ptag[i] == zap_line_va[31:12]) m_pv[i] = 0;
            for (int i = 0; i < 4; i++) if (m_dtag[i] == zap_line_va[31:22]) m_dv[i] = 0;
        end
        if (fill_valid && !(zap_line_valid && zap_line_va[31:12] == fill_vpn)) begin
            found = 0;
            for (int i = 0; i < 8; i++)
                if (m_pv[i] && m_ptag[i] == fill_vpn) begin
                    found = 1; m_pppn[i] = fill_ppn; m_pflg[i] = fill_flags;
                end
            if (!found) begin
                m_pv[m_pptr] = 1; m_ptag[m_pptr] = fill_vpn;
                m_pppn[m_pptr] = fill_ppn; m_pflg[m_pptr] = fill_flags;
                m_pptr = (m_pptr + 1) % 8;
            end
        end
        if (dfill_valid && !(zap_line_valid && zap_line_va[31:22] == dfill_dix)) begin
            found = 0;
            for (int i = 0; i < 4; i++)
                if (m_dv[i] && m_dtag[i] == dfill_dix) begin
                    found = 1; m_dbase[i] = dfill_base;
                end
            if (!found) begin
                m_dv[m_dptr] = 1; m_dtag[m_dptr] = dfill_dix; m_dbase[m_dptr] = dfill_base;
                m_dptr = (m_dptr + 1) % 4;
            end
        end
    endfunction

    task automatic clear_inputs();
        force_clr = 0; fault_done = 0; zap_all = 0; zap_line_valid = 0; zap_line_va = '0;
        fill_valid = 0; fill_vpn = '0; fill_ppn = '0; fill_flags = '0;
        dfill_valid = 0; dfill_dix = '0; dfill_base = '0;
        lookup_valid = 0; lookup_va = '0;
    endtask

    task automatic set_fill(input logic [31:0] va, input logic [19:0] p, input logic [7:0] f);
        fill_valid = 1; fill_vpn = va[31:12]; fill_ppn = p; fill_flags = f;
    endtask

    task automatic set_dfill(input logic [31:0] va, input logic [19:0] b);
        dfill_valid = 1; dfill_dix = va[31:22]; dfill_base = b;
    endtask

    task automatic set_zap(input logic [31:0] va);
        zap_line_valid = 1; zap_line_va = va;
    endtask

    task automatic set_look(input logic [31:0] va, input string req);
        lookup_valid = 1; lookup_va = va; cur_req = req;
    endtask

    // Driver: expectation from state before this edge, then model update
    task automatic step();
        if (lookup_valid) exp_q.push_back(model_look(lookup_va, cur_req));
        model_apply();
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic look(input logic [31:0] va, input string req);
        set_look(va, req);
        step();
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        end
    endtask

    // Monitor: compares each answer with the oldest expectation
    always @(posedge clk) begin
        #2;
        if (rst_n === 1'b1 && rsp_valid === 1'b1) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R2: unexpected response got rsp_valid=1 expected 0");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (rsp_hit !== e.hit || rsp_ppn !== e.ppn || rsp_flags !== e.flg ||
                    rsp_dir_hit !== e.dhit || rsp_pt_base !== e.base) begin
                    n_fail++;
                    $display("FAIL %s: got hit=%0b ppn=%h flg=%h dhit=%0b base=%h expected hit=%0b ppn=%h flg=%h dhit=%0b base=%h",
                             e.req, rsp_hit, rsp_ppn, rsp_flags, rsp_dir_hit, rsp_pt_base,
                             e.hit, e.ppn, e.flg, e.dhit, e.base);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got no end of test expected completion");
        report();
        $finish;
    end

    localparam logic [31:0] PA = 32'h1234_5000;
    localparam logic [31:0] PB = 32'h1234_6000;
    localparam logic [31:0] RR_BASE = 32'h4000_0000;

    initial begin
        for (int i = 0; i < 8; i++) begin m_pv[i] = 0; m_ptag[i] = '0; m_pppn[i] = '0; m_pflg[i] = '0; end
        for (int i = 0; i < 4; i++) begin m_dv[i] = 0; m_dtag[i] = '0; m_dbase[i] = '0; end
        m_pptr = 0; m_dptr = 0;
        rst_n = 0;
        clear_inputs();
        repeat (3) @(negedge clk);
        n_checks++;
        if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: during reset got rsp_valid=%0b rsp_hit=%0b expected 0 0", rsp_valid, rsp_hit);
        end
        rst_n = 1;
        @(negedge clk);

        // R1: empty after reset
        look(PA, "R1 reset miss");

        // R3: fill and hit with any offset; unrelated page misses
        set_fill(PA, 20'hABCDE, 8'h5A); step();
        look(PA | 32'hFFF, "R3 hit offset fff");
        look(PA | 32'h004, "R3 hit offset 004");
        look(32'h8765_4000, "R3 miss returns zero");

        // R2: lookup in the same cycle as a fill sees old contents
        set_look(PB, "R2 same-cycle fill not seen"); set_fill(PB, 20'h0BEEF, 8'hC3); step();
        look(PB, "R2 fill visible next");
        // R2: lookup in the same cycle as a shootdown still hits
        set_look(PA, "R2 same-cycle zap not seen"); set_zap(PA | 32'h7FF); step();
        // R4: shootdown with offset removed PA, PB kept
        look(PA, "R4 zapped page misses");
        look(PB, "R4 neighbour kept");

        // R11: directory fill and lookup
        set_dfill(PB, 20'h5_5555); step();
        look(PB, "R11 dir hit");
        look(32'h1280_0000, "R11 other region miss");
        // R5: shooting down a page inside the region drops the directory copy
        set_zap(32'h1200_0000 | 32'h0003_0123); step();
        look(PB, "R5 dir dropped");

        // R9: round robin over 8, ninth fill evicts first
        zap_all = 1; step();
        for (int i = 0; i < 9; i++) begin
            set_fill(RR_BASE + (i << 12), 20'h100 + 20'(i), 8'(i + 1)); step();
        end
        for (int i = 0; i < 9; i++) look(RR_BASE + (i << 12), "R9 round robin");
        // R10: refill in place, then the next new page takes slot 1
        set_fill(RR_BASE + (3 << 12), 20'h777, 8'hEE); step();
        set_fill(RR_BASE + (10 << 12), 20'h3AA, 8'h11); step();
        for (int i = 0; i < 11; i++) look(RR_BASE + (i << 12), "R10 in-place refill");

        // R11: directory round robin over 4
        for (int i = 0; i < 5; i++) begin
            set_dfill(32'h8000_0000 + (i << 22), 20'h200 + 20'(i)); step();
        end
        for (int i = 0; i < 5; i++) look(32'h8000_0000 + (i << 22), "R11 dir round robin");

        // R6: flush everything
        zap_all = 1; step();
        look(RR_BASE + (2 << 12), "R6 flush page");
        look(32'h8000_0000 + (2 << 22), "R6 flush dir");

        // R7: fault handled flushes
        set_fill(PA, 20'h00001, 8'h02); set_dfill(PA, 20'h00002); step();
        look(PA, "R7 before fault flush");
        fault_done = 1; step();
        look(PA, "R7 after fault flush");

        // R1: force clear empties the cache and pointer restarts at 0
        set_fill(PB, 20'h00003, 8'h04); step();
        force_clr = 1; step();
        look(PB, "R1 force clear miss");
        for (int i = 0; i < 9; i++) begin
            set_fill(RR_BASE + (i << 12), 20'h400 + 20'(i), 8'h80); step();
        end
        look(RR_BASE, "R9 pointer reset by flush");
        look(RR_BASE + (1 << 12), "R9 pointer reset by flush");

        // R8: invalidate wins over a same-cycle fill
        set_fill(32'h2000_1000, 20'h0AAAA, 8'h33); set_zap(32'h2000_1ABC); step();
        look(32'h2000_1000, "R8 zap beats fill");
        set_fill(32'h2000_2000, 20'h0BBBB, 8'h44); zap_all = 1; step();
        look(32'h2000_2000, "R8 flush beats fill");
        set_dfill(32'h2040_0000, 20'h0CCCC); set_zap(32'h2040_5000); step();
        look(32'h2040_0000, "R8 zap beats dir fill");
        set_fill(32'h2000_3000, 20'h0DDDD, 8'h55); set_zap(32'h2000_4000); step();
        look(32'h2000_3000, "R8 other page fill kept");

        repeat (3) @(negedge clk);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R2: missing responses got %0d pending expected 0", exp_q.size());
        end
        report();
        $finish;
    end

endmodule